// File: doc/BRIEF.md
# Three-Level Page Table Walker

The block turns a 32-bit virtual address into a physical page address by reading translation tables held in memory. It starts from a per-context root word, then descends through up to three table levels. Each fetched word is either a pointer to the next table or a leaf that maps a 16 MB, 256 KB or 4 KB page. A leaf carries a 3-bit access code that is checked against the kind of access: read, write or instruction fetch, by user or supervisor. It also carries referenced and modified flags, which the walker sets in memory when they are missing.

A request is handed over with a valid/ready handshake. The walker then owns a single 32-bit memory port until it returns either a translation (page address, page size, granted rights) or a coded fault. A fault also updates a fault status word, which flags an overflow when a fault arrives while the word is still non-zero, and a fault address word. When translation is switched off, addresses pass straight through. In boot mode, instruction fetches are steered into a boot ROM window.

Top module: `page_walker`

## Requirements
- R1: The root word is read at physical address (ctx_ptr_i << 4) + (ctx_num_i << 2). If the root word is invalid (type 0) the walk faults with code 0x004. If it is a leaf or reserved (type 2 or 3) it faults with code 0x010.
- R2: Bits [1:0] of every fetched word give its type: 0 invalid, 1 pointer, 2 leaf, 3 reserved. A pointer leads to the table at (word with bits [1:0] cleared) << 4. The entry within it is selected by virtual address bits [31:24] at level 1, [23:18] at level 2 and [17:12] at level 3, each times 4.
- R3: A leaf at level 1, 2 or 3 gives page_size_o 2 (16 MB), 1 (256 KB) or 0 (4 KB). paddr_o = (leaf bits [31:8] << 12) + the virtual address bits [23:12], [17:12] or none, placed at their own positions. Bits [11:0] of paddr_o are zero.
- R4: A walk fault reports err_o = (level << 8) | (kind << 2), with kind 1 for an invalid word and kind 4 for a reserved word, or a pointer found at level 3.
- R5: The access code is leaf bits [4:2]. A user access to code 6 or 7 faults with err_o 0x00C. An access whose needed right is missing faults with err_o 0x008. The needed rights are write for a write, execute for a fetch, and read otherwise. Supervisor rights by code 0..7 are R, RW, RX, RWX, X, RW, RX, RWX. User rights are the same, except R for code 5 and none for codes 6 and 7.
- R6: With ctl_nofault_i set, a user access that fails only the R5 check completes as a translation with the user rights, and the fault registers are left alone.
- R7: If the leaf's referenced bit (bit 5) is clear, or a write meets a clear modified bit (bit 6), the leaf is written back to the same address with bit 5 set, and with bit 6 also set for a write. Otherwise no write is issued.
- R8: perm_o = {execute, write, read} of the granted rights, with write removed while the leaf's modified bit (after any update) is clear.
- R9: With ctl_enable_i clear, the result is {virtual address bits [31:12], 12'b0}, page_size_o 0 and perm_o 3'b111, with no memory access.
- R10: With ctl_enable_i clear and ctl_boot_i set, a fetch returns prom_base_i OR virtual address bits [18:12] << 12, with perm_o 3'b101.
- R11: On a fault, fsr_o becomes (fsr_o != 0 ? 1 : 0) | ({write, fetch, supervisor} << 5) | err_o | 2. far_o becomes the virtual address with bits [11:0] cleared. Both are zero after reset.
- R12: req_ready_o is high only while no walk is in flight. It stays low from acceptance through the single-cycle done_o pulse.
- R13: While mem_req_o is high and mem_ready_i is low, the request, address, write enable and write data hold steady. Read data is taken in the cycle mem_ready_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Access is a write |
| req_fetch_i | input | 1 | Access is an instruction fetch |
| req_super_i | input | 1 | Access is from supervisor mode |
| ctl_enable_i | input | 1 | Translation enable |
| ctl_nofault_i | input | 1 | Suppress user permission faults |
| ctl_boot_i | input | 1 | Boot mode fetch redirect |
| ctx_ptr_i | input | 32 | Root table pointer |
| ctx_num_i | input | CTX_W | Context number |
| prom_base_i | input | PA_W | Boot ROM base |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | PA_W | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts / read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Result valid, one cycle |
| fault_o | output | 1 | Result is a fault |
| paddr_o | output | PA_W | Physical page address |
| page_size_o | output | 2 | 0: 4 KB, 1: 256 KB, 2: 16 MB |
| perm_o | output | 3 | Granted {execute, write, read} |
| err_o | output | 12 | Fault code, zero on success |
| fsr_o | output | 32 | Fault status word |
| far_o | output | 32 | Fault address word |

## Verification
One set of tables, placed in a memory model that stalls, is probed with walks ending at each depth. Leaf hits at levels 1, 2 and 3 separate the three page sizes and offset rules. Invalid, reserved and root-leaf words at different depths separate the level field from the kind field of the error code. User and supervisor reads, writes and fetches against several access codes separate privilege faults, missing-right faults and the no-fault override. Repeating a walk after its write-back shows that an up-to-date leaf is not rewritten. A run of faults with no clear in between exercises the overflow marking. The pass-through and boot cases show the two translation-off paths differ only for fetches.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;
  typedef enum logic [1:0] {ET_INVALID = 2'd0, ET_DIR = 2'd1, ET_LEAF = 2'd2, ET_RSVD = 2'd3} ent_type_e;
  typedef enum logic [1:0] {PG_4K = 2'd0, PG_256K = 2'd1, PG_16M = 2'd2} pg_size_e;
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_UPDATE, S_RESP} walk_state_e;

  localparam int unsigned REF_BIT = 5;
  localparam int unsigned MOD_BIT = 6;
  localparam logic [2:0]  KIND_INVALID = 3'd1;
  localparam logic [2:0]  KIND_RSVD    = 3'd4;

  function automatic logic [11:0] walk_err(input logic [1:0] lvl, input logic [2:0] kind);
    return {2'b00, lvl, 8'h00} | {7'b0, kind, 2'b00};
  endfunction

  // rights as {exec, write, read}
  function automatic logic [2:0] acc_rights(input logic [2:0] acc, input logic user);
    unique case (acc)
      3'd0: return 3'b001;
      3'd1: return 3'b011;
      3'd2: return 3'b101;
      3'd3: return 3'b111;
      3'd4: return 3'b100;
      3'd5: return user ? 3'b001 : 3'b011;
      3'd6: return user ? 3'b000 : 3'b101;
      default: return user ? 3'b000 : 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/pw_access_check.sv
module pw_access_check
  import page_walker_pkg::*;
(
  input  logic [2:0] acc_i,
  input  logic       user_i,
  input  logic       write_i,
  input  logic       fetch_i,
  output logic [3:0] err_o,
  output logic [2:0] grant_o
);
  logic [2:0] need;
  logic       priv_viol;

  always_comb begin
    grant_o   = acc_rights(acc_i, user_i);
    need      = {fetch_i, write_i, ~(fetch_i | write_i)};
    priv_viol = user_i & acc_i[2] & acc_i[1];
    if (priv_viol)                   err_o = 4'd12;
    else if ((need & ~grant_o) != 0) err_o = 4'd8;
    else                             err_o = 4'd0;
  end
endmodule

// File: rtl/pw_fault_log.sv
module pw_fault_log (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        log_i,
  input  logic [2:0]  acc_idx_i,
  input  logic [11:0] err_i,
  input  logic [31:0] vaddr_i,
  output logic [31:0] fsr_o,
  output logic [31:0] far_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_o <= '0;
      far_o <= '0;
    end else if (log_i) begin
      // a pending status collapses to the overflow marker first
      fsr_o <= ((fsr_o != 0) ? 32'd1 : 32'd0) | {24'b0, acc_idx_i, 5'b0}
               | {20'b0, err_i} | 32'd2;
      far_o <= {vaddr_i[31:12], 12'b0};
    end
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import page_walker_pkg::*;
#(
  parameter int unsigned PA_W  = 36,
  parameter int unsigned CTX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [31:0]      req_vaddr_i,
  input  logic             req_write_i,
  input  logic             req_fetch_i,
  input  logic             req_super_i,
  input  logic             ctl_enable_i,
  input  logic             ctl_nofault_i,
  input  logic             ctl_boot_i,
  input  logic [31:0]      ctx_ptr_i,
  input  logic [CTX_W-1:0] ctx_num_i,
  input  logic [PA_W-1:0]  prom_base_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ready_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [1:0]       page_size_o,
  output logic [2:0]       perm_o,
  output logic [11:0]      err_o,
  output logic [31:0]      fsr_o,
  output logic [31:0]      far_o
);
  localparam int unsigned LAST_LVL = 3;

  walk_state_e     state_q;
  logic [1:0]      lvl_q;
  logic [PA_W-1:0] ptr_q;
  logic [31:0]     vaddr_q, pte_q;
  logic            write_q, fetch_q, user_q, nofault_q;

  ent_type_e       etype;
  logic [7:0]      idx;
  logic [PA_W-1:0] next_ptr, leaf_pa, leaf_off;
  logic [31:0]     new_pte;
  logic            wb_need, fetch_fire, fault_now, prot_hit;
  logic [11:0]     err_now;
  logic [3:0]      chk_err;
  logic [2:0]      chk_grant;
  pg_size_e        leaf_size;

  pw_access_check u_check (
    .acc_i   (mem_rdata_i[4:2]),
    .user_i  (user_q),
    .write_i (write_q),
    .fetch_i (fetch_q),
    .err_o   (chk_err),
    .grant_o (chk_grant)
  );

  always_comb begin
    etype = ent_type_e'(mem_rdata_i[1:0]);
    unique case (lvl_q)
      2'd0:    idx = vaddr_q[31:24];
      2'd1:    idx = {2'b0, vaddr_q[23:18]};
      default: idx = {2'b0, vaddr_q[17:12]};
    endcase
    next_ptr = PA_W'({mem_rdata_i[31:2], 6'b0}) + PA_W'({idx, 2'b00});
    unique case (lvl_q)
      2'd1:    begin leaf_off = PA_W'({vaddr_q[23:12], 12'b0}); leaf_size = PG_16M;  end
      2'd2:    begin leaf_off = PA_W'({vaddr_q[17:12], 12'b0}); leaf_size = PG_256K; end
      default: begin leaf_off = '0;                              leaf_size = PG_4K;   end
    endcase
    leaf_pa  = PA_W'({mem_rdata_i[31:8], 12'b0}) + leaf_off;
    new_pte  = mem_rdata_i | (32'd1 << REF_BIT) | (write_q ? (32'd1 << MOD_BIT) : 32'd0);
    wb_need  = ~mem_rdata_i[REF_BIT] | (write_q & ~mem_rdata_i[MOD_BIT]);
    prot_hit = (chk_err != 4'd0) && !(nofault_q && user_q);

    fault_now = 1'b0;
    err_now   = '0;
    unique case (etype)
      ET_INVALID: begin fault_now = 1'b1; err_now = walk_err(lvl_q, KIND_INVALID); end
      ET_RSVD:    begin fault_now = 1'b1; err_now = walk_err(lvl_q, KIND_RSVD); end
      ET_DIR: if (lvl_q == 2'(LAST_LVL)) begin
        fault_now = 1'b1; err_now = walk_err(lvl_q, KIND_RSVD);
      end
      default: if (lvl_q == 2'd0) begin
        fault_now = 1'b1; err_now = walk_err(lvl_q, KIND_RSVD);
      end else if (prot_hit) begin
        fault_now = 1'b1; err_now = {8'b0, chk_err};
      end
    endcase
    fetch_fire = (state_q == S_FETCH) && mem_ready_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      lvl_q <= '0;  ptr_q <= '0;  vaddr_q <= '0;  pte_q <= '0;
      write_q <= 1'b0;  fetch_q <= 1'b0;  user_q <= 1'b0;  nofault_q <= 1'b0;
      fault_o <= 1'b0;  paddr_o <= '0;  page_size_o <= '0;  perm_o <= '0;  err_o <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          vaddr_q   <= req_vaddr_i;
          write_q   <= req_write_i;
          fetch_q   <= req_fetch_i;
          user_q    <= ~req_super_i;
          nofault_q <= ctl_nofault_i;
          lvl_q     <= '0;
          fault_o   <= 1'b0;
          err_o     <= '0;
          if (!ctl_enable_i) begin
            state_q     <= S_RESP;
            page_size_o <= PG_4K;
            if (ctl_boot_i && req_fetch_i) begin
              paddr_o <= prom_base_i | PA_W'({req_vaddr_i[18:12], 12'b0});
              perm_o  <= 3'b101;
            end else begin
              paddr_o <= PA_W'({req_vaddr_i[31:12], 12'b0});
              perm_o  <= 3'b111;
            end
          end else begin
            state_q <= S_FETCH;
            ptr_q   <= PA_W'({ctx_ptr_i, 4'b0}) + PA_W'({ctx_num_i, 2'b00});
          end
        end
        S_FETCH: if (mem_ready_i) begin
          if (fault_now) begin
            state_q <= S_RESP;
            fault_o <= 1'b1;
            err_o   <= err_now;
          end else if (etype == ET_DIR) begin
            ptr_q <= next_ptr;
            lvl_q <= lvl_q + 2'd1;
          end else begin
            pte_q       <= new_pte;
            paddr_o     <= leaf_pa;
            page_size_o <= leaf_size;
            perm_o      <= chk_grant & ~(new_pte[MOD_BIT] ? 3'b000 : 3'b010);
            state_q     <= wb_need ? S_UPDATE : S_RESP;
          end
        end
        S_UPDATE: if (mem_ready_i) state_q <= S_RESP;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  pw_fault_log u_flog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .log_i     (fetch_fire && fault_now),
    .acc_idx_i ({write_q, fetch_q, ~user_q}),
    .err_i     (err_now),
    .vaddr_i   (vaddr_q),
    .fsr_o     (fsr_o),
    .far_o     (far_o)
  );

  assign req_ready_o = (state_q == S_IDLE);
  assign done_o      = (state_q == S_RESP);
  assign mem_req_o   = (state_q == S_FETCH) || (state_q == S_UPDATE);
  assign mem_we_o    = (state_q == S_UPDATE);
  assign mem_addr_o  = ptr_q;
  assign mem_wdata_o = pte_q;
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
  parameter int unsigned PA_W = 36
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic [31:0]     mem_wdata_o,
  input logic            mem_ready_i,
  input logic            done_o,
  input logic            fault_o,
  input logic [11:0]     err_o,
  input logic [31:0]     fsr_o,
  input logic [31:0]     far_o
);
  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_on_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_ready_o);
  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);
  assert_hold_req_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)));
  assert_fault_coded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (err_o != 12'd0 && fsr_o[1]));
  assert_ok_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (err_o == 12'd0));
  assert_far_page_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (far_o[11:0] == 12'd0));
endmodule

bind page_walker page_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .err_o       (err_o),
  .fsr_o       (fsr_o),
  .far_o       (far_o)
);

// File: tb/page_walker_tb.sv
module page_walker_tb;
  localparam int PA_W = 36;
  localparam int CTX_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_super = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic en = 1'b1, nf = 1'b0, boot = 1'b0;
  logic [31:0] ctx_ptr = 32'h10;
  logic [CTX_W-1:0] ctx_num = 8'd2;
  logic [PA_W-1:0] prom_base = 36'hF_F000_0000;
  logic mem_req, mem_we, mem_ready = 1'b1, done, fault, req_ready;
  logic [PA_W-1:0] mem_addr, paddr;
  logic [31:0] mem_wdata, mem_rdata, fsr, far;
  logic [1:0] psz;
  logic [2:0] perm;
  logic [11:0] err;

  page_walker #(.PA_W(PA_W), .CTX_W(CTX_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write), .req_fetch_i(req_fetch),
    .req_super_i(req_super), .ctl_enable_i(en), .ctl_nofault_i(nf), .ctl_boot_i(boot),
    .ctx_ptr_i(ctx_ptr), .ctx_num_i(ctx_num), .prom_base_i(prom_base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata), .done_o(done), .fault_o(fault),
    .paddr_o(paddr), .page_size_o(psz), .perm_o(perm), .err_o(err), .fsr_o(fsr), .far_o(far));

  // memory model with periodic stalls
  logic [31:0] mem [4096];
  int writes = 0;
  logic [1:0] stall_cnt = '0;
  assign mem_rdata = mem[mem_addr[13:2]];
  always @(negedge clk) begin
    stall_cnt <= stall_cnt + 2'd1;
    mem_ready <= (stall_cnt != 2'd0);
  end
  always @(posedge clk) if (mem_req && mem_we && mem_ready) begin
    mem[mem_addr[13:2]] <= mem_wdata;
    writes <= writes + 1;
  end

  typedef struct {
    logic [PA_W-1:0] pa; logic [1:0] sz; logic [2:0] perm; logic flt;
    logic [11:0] err; logic [31:0] fsr; logic [31:0] far; string tag;
  } exp_t;
  exp_t sb_q[$];
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n && done) begin
    if (sb_q.size() == 0) begin
      chk("R12", "unexpected result", 1, 0);
    end else begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, "fault", fault, e.flt);
      chk(e.tag, "err", err, e.err);
      chk(e.tag, "fsr", fsr, e.fsr);
      chk(e.tag, "far", far, e.far);
      chk("R12", "ready during done", req_ready, 0);
      if (!e.flt) begin
        chk(e.tag, "paddr", paddr, e.pa);
        chk(e.tag, "size", psz, e.sz);
        chk(e.tag, "perm", perm, e.perm);
      end
    end
  end

  task automatic walk(input logic [31:0] va, input bit wr, input bit fe, input bit sup, input exp_t e);
    sb_q.push_back(e);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_fetch = fe; req_super = sup; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12", "ready after accept", req_ready, 0);
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk("R12", "ready after done", req_ready, 1);
  endtask

  function automatic exp_t ok(input logic [PA_W-1:0] pa, input logic [1:0] sz, input logic [2:0] p,
                              input logic [31:0] fs, input logic [31:0] fa, input string tag);
    exp_t e;
    e.pa = pa; e.sz = sz; e.perm = p; e.flt = 1'b0; e.err = '0; e.fsr = fs; e.far = fa; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t bad(input logic [11:0] ec, input logic [31:0] fs, input logic [31:0] fa,
                               input string tag);
    exp_t e;
    e.pa = '0; e.sz = '0; e.perm = '0; e.flt = 1'b1; e.err = ec; e.fsr = fs; e.far = fa; e.tag = tag;
    return e;
  endfunction

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem['h108 >> 2] = 32'h0000_0041;  // root ctx 2 -> level-1 table at 0x400
    mem['h10C >> 2] = 32'h0000_0002;  // root ctx 3 is a leaf
    mem['h404 >> 2] = 32'h0012_346E;  // 16MB leaf, code 3, ref+mod
    mem['h408 >> 2] = 32'h0000_0081;  // -> level-2 table at 0x800
    mem['h410 >> 2] = 32'h0000_017A;  // 16MB leaf, code 6
    mem['h808 >> 2] = 32'h0050_0026;  // 256KB leaf, code 1, ref only
    mem['h80C >> 2] = 32'h0000_0091;  // -> level-3 table at 0x900
    mem['h810 >> 2] = 32'h0060_0026;  // 256KB leaf, code 1, ref only
    mem['h914 >> 2] = 32'h0ABC_DE0A;  // 4KB leaf, code 2, no flags
    mem['h918 >> 2] = 32'h0000_0003;  // reserved

    repeat (3) @(negedge clk);
    chk("R12", "reset ready", req_ready, 1);
    chk("R12", "reset done", done, 0);
    chk("R13", "reset mem_req", mem_req, 0);
    chk("R11", "reset fsr", fsr, 0);
    chk("R11", "reset far", far, 0);
    rst_n = 1'b1;
    @(negedge clk);

    walk(32'h0155_6000, 0, 0, 1, ok(36'h0_0178_A000, 2, 3'b111, 0, 0, "R1 R3 16MB"));
    walk(32'h0208_3000, 1, 0, 0, ok(36'h0_0500_3000, 1, 3'b011, 0, 0, "R2 R7 256KB write"));
    chk("R7", "writeback modified", mem['h808 >> 2], 32'h0050_0066);
    walk(32'h020C_5000, 0, 1, 0, ok(36'h0_ABCD_E000, 0, 3'b101, 0, 0, "R3 R5 4KB fetch"));
    chk("R7", "writeback referenced", mem['h914 >> 2], 32'h0ABC_DE2A);
    walk(32'h0208_3000, 0, 0, 0, ok(36'h0_0500_3000, 1, 3'b011, 0, 0, "R7 no update"));
    chk("R7", "write count", writes, 2);
    walk(32'h0210_0000, 0, 0, 1, ok(36'h0_0600_0000, 1, 3'b001, 0, 0, "R8 write withheld"));
    chk("R7", "no write on read", writes, 2);

    walk(32'h0300_0000, 0, 0, 1, bad(12'h104, 32'h126, 32'h0300_0000, "R4 R11 level1 invalid"));
    walk(32'h0400_0000, 0, 0, 0, bad(12'h00C, 32'h00F, 32'h0400_0000, "R5 R11 privilege"));
    walk(32'h020C_6000, 1, 0, 1, bad(12'h310, 32'h3B3, 32'h020C_6000, "R4 level3 reserved"));
    nf = 1'b1;
    walk(32'h0400_0000, 0, 0, 0, ok(36'h0_0000_1000, 2, 3'b000, 32'h3B3, 32'h020C_6000, "R6 no-fault"));
    nf = 1'b0;
    ctx_num = 8'd3;
    walk(32'h0500_0000, 1, 0, 0, bad(12'h010, 32'h093, 32'h0500_0000, "R1 root leaf"));
    ctx_num = 8'd2;
    walk(32'h020C_5000, 1, 0, 1, bad(12'h008, 32'h0AB, 32'h020C_5000, "R5 protection"));
    walk(32'h020C_7000, 0, 0, 0, bad(12'h304, 32'h307, 32'h020C_7000, "R4 level3 invalid"));

    en = 1'b0;
    walk(32'h1234_5678, 1, 0, 1, ok(36'h0_1234_5000, 0, 3'b111, 32'h307, 32'h020C_7000, "R9 pass"));
    boot = 1'b1;
    walk(32'h1234_5678, 0, 1, 0, ok(36'hF_F004_5000, 0, 3'b101, 32'h307, 32'h020C_7000, "R10 boot fetch"));
    walk(32'h1234_5678, 0, 0, 0, ok(36'h0_1234_5000, 0, 3'b111, 32'h307, 32'h020C_7000, "R10 boot read"));
    chk("R9", "no memory traffic", writes, 2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R12 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule